// File: doc/BRIEF.md
# Multi-Channel Closed-Loop Supply Trim Controller

This block steers up to eight power-supply trim DACs, six by default, toward voltage set points. Each channel holds an 8-bit trim code with the bipolar midpoint at 80h. When closed-loop operation is off, a code comes only from the preset bank picked by two profile-select pins or from a direct register write. When the active-low enable is asserted, the block visits the channels in the loop mask in turn. On each visit it starts one conversion on a shared ADC, compares the 10-bit reading with that channel's target, and moves the code by one LSB toward the target unless the error is inside a programmable deadband.

A rising code is taken to raise the supply, so its reading rises too. After any code change, the block waits a settling interval before the next conversion. A conversion ends when the ADC signals done, or after a fixed conversion time, whichever comes first. Both intervals are counted in microsecond ticks made by a clock prescaler. A channel counts as locked after a programmable number of in-band readings in a row, and a single lock output reports on all masked channels together. Codes saturate at 00h and FFh, and a channel pinned at a rail raises its own rail-hit bit.

Top module: `trim_loop_ctrl`

## Requirements
- R1: After reset every trim code is 80h, no write strobe, rail bit, lock or ADC request is active, every target is 200h, every preset is 80h, the deadband is 2, the lock count is 3 and all channels are in the loop mask.
- R2: A change of `prof_sel` loads preset bank `prof_sel` into every channel on the next clock. It pulses all `dac_wr` bits for one cycle and clears every channel's lock and rail state. Preset for profile p and channel c is written at register address (p+1)*8+c.
- R3: A write to address 40+c (c < NCH) sets channel c's code to `reg_wdata[7:0]` on the next clock, with a one-cycle strobe on `dac_wr[c]` only. If `prof_sel` changes in the same cycle, the profile load wins.
- R4: While `loop_en_n` is high no ADC request is issued, codes change only through R2 and R3, and `lock` is low.
- R5: In closed loop, the masked channels are visited in ascending order, wrapping to 0. Each visit issues a one-cycle `adc_req` with `adc_ch` holding the channel number.
- R6: With reading D, target T and deadband B, the code goes up by one when D+B < T, goes down by one when D > T+B, and stays the same otherwise, so both band edges count as in band. Target for channel c is at address c. The deadband is `reg_wdata[4:0]` at address 48.
- R7: A channel locks after N in-band readings in a row and unlocks on any out-of-band reading. N is `reg_wdata[3:0]` at address 49, and a written 0 is taken as 1.
- R8: `lock` is high only while the loop is enabled, the mask (`reg_wdata[NCH-1:0]` at address 50) is non-zero, and every masked channel is locked.
- R9: A step that would pass FFh or 00h leaves the code at the rail and sets that channel's `rail_hit`. The bit clears when the channel's code is next written.
- R10: After any code change, and after the loop is enabled, no ADC request is issued until SETTLE_US*PRESCALE cycles have passed.
- R11: A reading is taken in the cycle `adc_done` is high. If done does not arrive, `adc_data` is taken after CONV_US*PRESCALE cycles of waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loop_en_n | input | 1 | Closed-loop enable, active low |
| prof_sel | input | 2 | Preset profile select |
| adc_req | output | 1 | Conversion request pulse |
| adc_ch | output | 3 | Channel to convert |
| adc_done | input | 1 | Conversion complete |
| adc_data | input | 10 | Conversion result |
| dac_code | output | NCH*8 | Trim codes, channel c at bits [8c+7:8c] |
| dac_wr | output | NCH | One-cycle strobe per changed code |
| lock | output | 1 | All masked channels locked |
| rail_hit | output | NCH | Channel pinned at a code limit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (group*8 + channel) |
| reg_wdata | input | 10 | Register write data |

## Verification
The bench places readings exactly on the deadband edge and just past it. A design with a strict comparison would step there, and one with an inclusive comparison on the wrong side would fail to correct a reading one LSB out of band. It counts conversions up to lock for a lock count of five and for a written zero, which catches an off-by-one streak counter or a zero count that never locks. It drives codes into both rails to catch a wrapping adder and a rail bit that never sets or never clears. It also measures the request-to-strobe and strobe-to-request distances with and without the done flag, to catch a missing timeout or a settle wait that is too short.

// File: rtl/trim_loop_ctrl.sv
module trim_loop_ctrl #(
  parameter int NCH       = 6,
  parameter int CODE_W    = 8,
  parameter int ADC_W     = 10,
  parameter int PRESCALE  = 50,
  parameter int SETTLE_US = 256,
  parameter int CONV_US   = 200
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    loop_en_n,
  input  logic [1:0]              prof_sel,
  output logic                    adc_req,
  output logic [2:0]              adc_ch,
  input  logic                    adc_done,
  input  logic [ADC_W-1:0]        adc_data,
  output logic [NCH*CODE_W-1:0]   dac_code,
  output logic [NCH-1:0]          dac_wr,
  output logic                    lock,
  output logic [NCH-1:0]          rail_hit,
  input  logic                    reg_we,
  input  logic [5:0]              reg_addr,
  input  logic [ADC_W-1:0]        reg_wdata
);

  localparam int PW   = $clog2(PRESCALE + 1);
  localparam int TMAX = (SETTLE_US > CONV_US) ? SETTLE_US : CONV_US;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] TOP  = {CODE_W{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_PICK, S_REQ, S_WAIT, S_SETTLE} st_t;

  st_t st, nst;
  logic [2:0]        ptr, prof_q;
  logic [PW-1:0]     pcnt;
  logic [TW-1:0]     tcnt;
  logic [ADC_W-1:0]  tgt [NCH];
  logic [CODE_W-1:0] pre [4][NCH];
  logic [CODE_W-1:0] code [NCH];
  logic [3:0]        run [NCH];
  logic [NCH-1:0]    wr_q, rail_q, lck_q, mask;
  logic [4:0]        db;
  logic [3:0]        nlock;

  wire       en       = ~loop_en_n;
  wire [2:0] grp      = reg_addr[5:3];
  wire [2:0] wch      = reg_addr[2:0];
  wire       ch_ok    = 32'(wch) < NCH;
  wire       prof_chg = prof_sel != prof_q[1:0];
  wire       dir_wr   = reg_we && grp == 3'd5 && ch_ok;
  wire       ext_chg  = prof_chg || dir_wr;
  wire       tick     = pcnt == PW'(PRESCALE - 1);
  wire       settled  = tick && tcnt == TW'(SETTLE_US - 1);
  wire       conv_to  = tick && tcnt == TW'(CONV_US - 1);
  wire       sample   = st == S_WAIT && en && !ext_chg && (adc_done || conv_to);
  wire [2:0] nxt      = (ptr == 3'(NCH - 1)) ? 3'd0 : ptr + 3'd1;

  wire [ADC_W:0]     rd   = {1'b0, adc_data};
  wire [ADC_W:0]     tg   = {1'b0, tgt[ptr]};
  wire [ADC_W:0]     dbx  = (ADC_W + 1)'(db);
  wire               up   = sample && (rd + dbx < tg);
  wire               dn   = sample && (rd > tg + dbx);
  wire [CODE_W-1:0]  cur  = code[ptr];
  wire               step = (up && cur != TOP) || (dn && cur != '0);
  wire [3:0]         rinc = (run[ptr] == 4'hF) ? 4'hF : run[ptr] + 4'd1;

  always_comb begin
    nst = st;
    case (st)
      S_IDLE:   nst = S_SETTLE;
      S_PICK:   if (mask[ptr]) nst = S_REQ;
      S_REQ:    nst = S_WAIT;
      S_WAIT:   if (sample) nst = step ? S_SETTLE : S_PICK;
      S_SETTLE: if (settled) nst = S_PICK;
      default:  nst = S_IDLE;
    endcase
    if (!en) nst = S_IDLE;
    else if (ext_chg) nst = S_SETTLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      prof_q <= '0;
      pcnt   <= '0;
      tcnt   <= '0;
    end else begin
      st     <= nst;
      prof_q <= {1'b0, prof_sel};
      if (nst != st || ext_chg) begin
        pcnt <= '0;
        tcnt <= '0;
      end else if (tick) begin
        pcnt <= '0;
        tcnt <= tcnt + 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
      if (sample || (st == S_PICK && nst == S_PICK)) ptr <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db    <= 5'd2;
      nlock <= 4'd3;
      mask  <= '1;
      for (int i = 0; i < NCH; i++) begin
        tgt[i] <= ADC_W'(1 << (ADC_W - 1));
        for (int p = 0; p < 4; p++) pre[p][i] <= MID;
      end
    end else if (reg_we) begin
      for (int i = 0; i < NCH; i++) begin
        if (wch == 3'(i)) begin
          if (grp == 3'd0) tgt[i] <= reg_wdata;
          for (int p = 0; p < 4; p++)
            if (grp == 3'(p + 1)) pre[p][i] <= reg_wdata[CODE_W-1:0];
        end
      end
      if (grp == 3'd6) begin
        case (wch)
          3'd0: db    <= reg_wdata[4:0];
          3'd1: nlock <= (reg_wdata[3:0] == 4'd0) ? 4'd1 : reg_wdata[3:0];
          3'd2: mask  <= reg_wdata[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rail_q <= '0;
      lck_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        code[i] <= MID;
        run[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        wr_q[i] <= 1'b0;
        if (prof_chg) begin
          code[i]   <= pre[prof_sel][i];
          wr_q[i]   <= 1'b1;
          rail_q[i] <= 1'b0;
          run[i]    <= '0;
          lck_q[i]  <= 1'b0;
        end else if (dir_wr && wch == 3'(i)) begin
          code[i]   <= reg_wdata[CODE_W-1:0];
          wr_q[i]   <= 1'b1;
          rail_q[i] <= 1'b0;
          run[i]    <= '0;
          lck_q[i]  <= 1'b0;
        end else if (sample && ptr == 3'(i)) begin
          if (up || dn) begin
            run[i]   <= '0;
            lck_q[i] <= 1'b0;
            if (step) begin
              code[i]   <= up ? code[i] + 1'b1 : code[i] - 1'b1;
              wr_q[i]   <= 1'b1;
              rail_q[i] <= 1'b0;
            end else begin
              rail_q[i] <= 1'b1;
            end
          end else begin
            run[i]   <= rinc;
            lck_q[i] <= rinc >= nlock;
          end
        end
        if (!en) begin
          run[i]   <= '0;
          lck_q[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign dac_code[g*CODE_W +: CODE_W] = code[g];
  end

  assign adc_req  = st == S_REQ;
  assign adc_ch   = ptr;
  assign dac_wr   = wr_q;
  assign rail_hit = rail_q;
  assign lock     = en && (|mask) && (&(lck_q | ~mask));

endmodule

// File: rtl/trim_loop_ctrl_chk.sv
module trim_loop_ctrl_chk #(
  parameter int NCH       = 6,
  parameter int CODE_W    = 8,
  parameter int PRESCALE  = 50,
  parameter int SETTLE_US = 256
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  loop_en_n,
  input logic [1:0]            prof_sel,
  input logic                  adc_req,
  input logic [NCH*CODE_W-1:0] dac_code,
  input logic [NCH-1:0]        dac_wr,
  input logic                  lock,
  input logic [NCH-1:0]        rail_hit
);

  localparam int unsigned GAP = SETTLE_US * PRESCALE;
  int unsigned since_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_wr <= GAP + 1;
    else if (|dac_wr) since_wr <= 1;
    else if (since_wr <= GAP) since_wr <= since_wr + 1;
  end

  assert_settle_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |-> since_wr > GAP);

  assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |=> !adc_req);

  assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en_n |=> !adc_req);

  assert_strobe_on_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> (|dac_wr));

  assert_profile_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prof_sel != $past(prof_sel)) |=> !lock);

  for (genvar g = 0; g < NCH; g++) begin : g_rail
    assert_rail_at_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rail_hit[g] |-> (dac_code[g*CODE_W +: CODE_W] == '0 ||
                       dac_code[g*CODE_W +: CODE_W] == '1));
  end

endmodule

bind trim_loop_ctrl trim_loop_ctrl_chk #(
  .NCH(NCH), .CODE_W(CODE_W), .PRESCALE(PRESCALE), .SETTLE_US(SETTLE_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .loop_en_n(loop_en_n), .prof_sel(prof_sel),
  .adc_req(adc_req), .dac_code(dac_code), .dac_wr(dac_wr), .lock(lock),
  .rail_hit(rail_hit)
);

// File: tb/trim_loop_ctrl_bench.sv
module trim_loop_ctrl_bench;
  localparam int NCH = 6, PRE = 2, SET = 4, CONV = 5;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n, loop_en_n, adc_done, adc_req, lock, reg_we;
  logic [1:0] prof_sel;
  logic [2:0] adc_ch;
  logic [9:0] adc_data, reg_wdata;
  logic [5:0] reg_addr;
  logic [NCH*8-1:0] dac_code;
  logic [NCH-1:0] dac_wr, rail_hit;

  trim_loop_ctrl #(.NCH(NCH), .PRESCALE(PRE), .SETTLE_US(SET), .CONV_US(CONV)) u_trim_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .loop_en_n(loop_en_n), .prof_sel(prof_sel),
    .adc_req(adc_req), .adc_ch(adc_ch), .adc_done(adc_done), .adc_data(adc_data),
    .dac_code(dac_code), .dac_wr(dac_wr), .lock(lock), .rail_hit(rail_hit),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata));

  int checks = 0, fails = 0, cyc = 0;
  int base [NCH];
  int done_dly = 3;
  bit mute = 0, rr_on = 0, rr_have = 0;
  int rr_prev = 0, rr_err = 0, rr_cnt = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_ge(string req, int act, int lim);
    checks++;
    if (act < lim) begin
      fails++;
      $display("FAIL %s: actual %0d expected >= %0d", req, act, lim);
    end
  endtask

  function automatic int code_of(int i);
    return int'(dac_code[i*8 +: 8]);
  endfunction

  function automatic int model(int ch);
    int v = base[ch] + 4 * (code_of(ch) - 128);
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    bit busy = 0;
    int cnt = 0;
    adc_done = 0;
    adc_data = 0;
    forever begin
      @(negedge clk);
      adc_done = 0;
      if (busy) begin
        if (cnt > 0) cnt--;
        if (cnt == 0 && !mute) begin
          adc_done = 1;
          busy = 0;
        end
      end
      if (adc_req) begin
        busy = 1;
        cnt = done_dly;
        adc_data = 10'(model(int'(adc_ch)));
        if (rr_on) begin
          if (rr_have && int'(adc_ch) != (rr_prev + 1) % NCH) rr_err++;
          rr_have = 1;
          rr_prev = int'(adc_ch);
          rr_cnt++;
        end
      end
    end
  end

  task automatic wr_reg(int grp, int ch, int val);
    @(negedge clk);
    reg_we = 1;
    reg_addr = 6'(grp * 8 + ch);
    reg_wdata = 10'(val);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic enable_loop(bit on);
    @(negedge clk);
    loop_en_n = !on;
  endtask

  task automatic wait_lock(int limit);
    for (int k = 0; k < limit && !lock; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    for (int i = 0; i < NCH; i++) check("R1 reset code", code_of(i), 128);
    check("R1 reset strobes", int'(dac_wr), 0);
    check("R1 reset lock", int'(lock), 0);
    check("R1 reset request", int'(adc_req), 0);
    check("R1 reset rail", int'(rail_hit), 0);
  endtask

  task automatic t_profile;
    int reqs = 0;
    for (int i = 0; i < NCH; i++) wr_reg(3, i, 'h90 + i);
    for (int i = 0; i < NCH; i++) wr_reg(2, i, 'h40 + i);
    @(negedge clk); prof_sel = 2;
    @(negedge clk);
    check("R2 profile strobe all", int'(dac_wr), 63);
    for (int i = 0; i < NCH; i++) check("R2 profile code", code_of(i), 'h90 + i);
    @(negedge clk);
    check("R2 strobe one cycle", int'(dac_wr), 0);
    wr_reg(5, 3, 'h55);
    check("R3 direct code", code_of(3), 'h55);
    check("R3 direct strobe", int'(dac_wr), 8);
    check("R3 neighbour kept", code_of(2), 'h92);
    @(negedge clk);
    reg_we = 1; reg_addr = 6'(5 * 8 + 1); reg_wdata = 10'h11; prof_sel = 1;
    @(negedge clk);
    reg_we = 0;
    check("R3 profile wins", code_of(1), 'h41);
    check("R3 profile wins other", code_of(3), 'h43);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (adc_req) reqs++;
    end
    check("R4 no request when off", reqs, 0);
    check("R4 code held when off", code_of(0), 'h40);
    check("R4 lock low when off", int'(lock), 0);
    @(negedge clk); prof_sel = 0;
    @(negedge clk);
    check("R2 back to profile 0", code_of(5), 128);
  endtask

  task automatic t_converge;
    int kk [NCH] = '{5, -3, 0, 7, -6, 2};
    wr_reg(6, 0, 2);
    wr_reg(6, 1, 3);
    wr_reg(6, 2, 63);
    for (int i = 0; i < NCH; i++) wr_reg(0, i, base[i] + 4 * kk[i]);
    rr_have = 0; rr_err = 0; rr_cnt = 0; rr_on = 1;
    enable_loop(1);
    wait_lock(6000);
    check("R8 lock after convergence", int'(lock), 1);
    for (int i = 0; i < NCH; i++) check("R6 converged code", code_of(i), 128 + kk[i]);
    rr_on = 0;
    check("R5 round robin order", rr_err, 0);
    check_ge("R5 visits made", rr_cnt, 3 * NCH);
    enable_loop(0);
    @(negedge clk);
    check("R8 lock drops when off", int'(lock), 0);
  endtask

  task automatic t_deadband;
    int wrs = 0;
    wr_reg(6, 2, 1);
    wr_reg(5, 0, 128);
    wr_reg(0, 0, 402);
    enable_loop(1);
    for (int k = 0; k < 2000 && !lock; k++) begin
      @(negedge clk);
      if (dac_wr[0]) wrs++;
    end
    check("R6 band edge no step", code_of(0), 128);
    check("R6 band edge no strobe", wrs, 0);
    check("R8 single-channel mask lock", int'(lock), 1);
    enable_loop(0);
    wr_reg(0, 0, 403);
    enable_loop(1);
    wait_lock(2000);
    check("R6 just outside band steps up", code_of(0), 129);
    enable_loop(0);
    wr_reg(0, 0, 397);
    enable_loop(1);
    wait_lock(2000);
    check("R6 above band steps down", code_of(0), 127);
    enable_loop(0);
  endtask

  task automatic count_to_lock(output int n);
    n = 0;
    for (int k = 0; k < 3000 && !lock; k++) begin
      @(negedge clk);
      if (adc_req) n++;
    end
  endtask

  task automatic t_lockcount;
    int n;
    wr_reg(6, 1, 5);
    enable_loop(1);
    count_to_lock(n);
    check("R7 lock after five samples", n, 5);
    enable_loop(0);
    wr_reg(6, 1, 0);
    enable_loop(1);
    count_to_lock(n);
    check("R7 zero count acts as one", n, 1);
    wr_reg(0, 0, 1000);
    for (int k = 0; k < 200 && lock; k++) @(negedge clk);
    check("R7 out-of-band unlocks", int'(lock), 0);
    enable_loop(0);
    wr_reg(6, 1, 3);
  endtask

  task automatic t_rail;
    wr_reg(5, 0, 'hF8);
    wr_reg(0, 0, 1023);
    enable_loop(1);
    for (int k = 0; k < 2000 && !rail_hit[0]; k++) @(negedge clk);
    check("R9 high rail flag", int'(rail_hit[0]), 1);
    check("R9 high rail code", code_of(0), 255);
    repeat (100) @(negedge clk);
    check("R9 high rail holds", code_of(0), 255);
    check("R9 pinned channel not locked", int'(lock), 0);
    enable_loop(0);
    wr_reg(5, 0, 'h80);
    check("R9 flag clears on write", int'(rail_hit[0]), 0);
    base[0] = 700;
    wr_reg(5, 0, 'h05);
    wr_reg(0, 0, 0);
    enable_loop(1);
    for (int k = 0; k < 2000 && !rail_hit[0]; k++) @(negedge clk);
    check("R9 low rail flag", int'(rail_hit[0]), 1);
    check("R9 low rail code", code_of(0), 0);
    enable_loop(0);
    base[0] = 400;
  endtask

  task automatic wait_req(output int c);
    c = -1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (adc_req) begin c = cyc; break; end
    end
  endtask

  task automatic wait_wr0(output int c);
    c = -1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (dac_wr[0]) begin c = cyc; break; end
    end
  endtask

  task automatic t_timing;
    int r, w, r2, w2;
    wr_reg(5, 0, 'h80);
    wr_reg(0, 0, 1000);
    done_dly = 3;
    enable_loop(1);
    wait_req(r);
    check("R5 channel on request", int'(adc_ch), 0);
    wait_wr0(w);
    check("R11 step follows done", w - r, done_dly + 1);
    mute = 1;
    wait_req(r2);
    check_ge("R10 settle before next request", r2 - w, SET * PRE + 1);
    wait_wr0(w2);
    check("R11 timeout takes reading", w2 - r2, CONV * PRE + 1);
    mute = 0;
    enable_loop(0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) base[i] = 400 + 8 * i;
    rst_n = 0; loop_en_n = 1; prof_sel = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_profile();
    t_converge();
    t_deadband();
    t_lockcount();
    t_rail();
    t_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule